// File: doc/BRIEF.md
# Serial-Loaded Wiper Position Controller

This block is the digital front end of a digitally programmed resistor. A host writes a wiper code over a three-wire serial port made of an active-low select, a serial clock and a data line. Bits enter a shift register and move to a holding latch when the select is released. The latch drives the tap decoder of the resistor ladder. A system reset presets the latch to the middle of the range.

A parameter picks one of two variants. The wide variant takes an 8-bit code for 256 positions. The narrow variant takes a 6-bit code that addresses 33 positions. An active-low shutdown input raises a shutdown flag for the analog side. Shutdown leaves the latch untouched, and the serial port keeps working while it is asserted. Any code loaded during shutdown takes effect when shutdown is released.

All four port inputs are asynchronous to the system clock. Each passes through a two-stage synchronizer, and edges on select and serial clock are found in the system clock domain. The system clock must run at least four times faster than the serial clock. A one-cycle pulse marks each write of the latch.

Top module: `wpot_ctrl`

## Requirements
- R1: At reset the latch holds midscale: 0x80 in the 8-bit variant and 0x10 in the 6-bit variant. The shift register clears to zero, the update pulse is low, and the shutdown flag is low while the shutdown input is high.
- R2: While select is low, each rising serial clock edge shifts the data bit into the least significant end of the shift register, so a word is sent most significant bit first. A word of exactly the code width shows up unchanged on the code output after select rises.
- R3: The code output changes only on a rising edge of select. It holds its value while bits are being shifted in.
- R4: Serial clock edges while select is high leave the shift register unchanged.
- R5: If select rises after fewer or more clock edges than the code width, the latch loads the shift register as it stands, which is the last code-width bits shifted in. No error is signalled.
- R6: The shutdown flag is high while the shutdown input is low. Asserting or releasing shutdown leaves the code output unchanged.
- R7: While shutdown is asserted, serial words are still shifted and latched, and the new code is visible on the code output.
- R8: Every rising edge of select produces exactly one update pulse, one system cycle wide, in the cycle the latch is written.
- R9: The 6-bit variant loads the low six bits of the serial stream and uses a 6-bit midscale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, rising edge active, asynchronous |
| sdata | input | 1 | Serial data, asynchronous |
| shdn_n | input | 1 | Shutdown request, active low, asynchronous |
| wiper_code | output | CODE_W | Latched wiper code (8 or 6 bits) |
| shutdown | output | 1 | High while shutdown is requested |
| code_load | output | 1 | One-cycle pulse when the latch is written |

## Verification
The assertions assume that select and serial clock never have two rising edges in successive system cycles. They also assume that data is stable when a sampled serial clock edge arrives, which follows from the four-to-one clock ratio. The stimulus holds every serial line level for four system cycles and changes data only while the serial clock is low. It never moves select and the serial clock in the same cycle. Random frames of 1 to 12 bits and random shutdown toggles are mixed with directed cases: clocks with select high, an empty frame, and loads during shutdown.

// File: rtl/wpot_pkg.sv
package wpot_pkg;
    localparam int WIDE_W     = 8;
    localparam int NARROW_W   = 6;
    localparam int WIDE_MID   = 'h80;
    localparam int NARROW_MID = 'h10;

    // index of each line inside the synchronized input vector
    localparam int IN_SEL  = 0;
    localparam int IN_SCLK = 1;
    localparam int IN_DATA = 2;
    localparam int IN_SHDN = 3;
    localparam int IN_NUM  = 4;
endpackage

// File: rtl/wpot_sync.sv
module wpot_sync #(
    parameter int             N       = 4,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/wpot_core.sv
module wpot_core #(
    parameter int W   = 8,
    parameter int MID = 'h80
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_lvl,
    input  logic         sclk_lvl,
    input  logic         data_lvl,
    output logic [W-1:0] code,
    output logic         load
);
    typedef struct packed {
        logic [W-1:0] sr;
        logic [W-1:0] code;
        logic         load;
        logic         sel_prev;
        logic         sclk_prev;
    } core_t;

    core_t st_d, st_q;
    logic  sel_rise, sclk_rise;

    assign sel_rise  = sel_lvl & ~st_q.sel_prev;
    assign sclk_rise = sclk_lvl & ~st_q.sclk_prev;

    always_comb begin
        st_d           = st_q;
        st_d.sel_prev  = sel_lvl;
        st_d.sclk_prev = sclk_lvl;
        st_d.load      = 1'b0;
        if (!sel_lvl && sclk_rise) begin
            st_d.sr = {st_q.sr[W-2:0], data_lvl};
        end
        if (sel_rise) begin
            st_d.code = st_q.sr;
            st_d.load = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sr        <= '0;
            st_q.code      <= W'(MID);
            st_q.load      <= 1'b0;
            st_q.sel_prev  <= 1'b1;
            st_q.sclk_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.code;
    assign load = st_q.load;

    // R2 / R5: a select edge moves the shift register into the latch
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_lvl && !st_q.sel_prev) |=> (st_q.code == $past(st_q.sr)));

    // R3: without a select edge the latch keeps its value
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_lvl && !st_q.sel_prev) |=> $stable(st_q.code));

    // R4: with select high the shift register stays put
    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_lvl |=> $stable(st_q.sr));

    // R8: the update pulse lasts a single cycle
    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.load |=> !st_q.load);

    // R8: a select edge always raises the update pulse
    p_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_lvl && !st_q.sel_prev) |=> st_q.load);
endmodule

// File: rtl/wpot_ctrl.sv
module wpot_ctrl #(
    parameter bit WIDE         = 1'b1,
    localparam int CODE_W      = WIDE ? wpot_pkg::WIDE_W : wpot_pkg::NARROW_W,
    localparam int CODE_MID    = WIDE ? wpot_pkg::WIDE_MID : wpot_pkg::NARROW_MID
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sclk,
    input  logic              sdata,
    input  logic              shdn_n,
    output logic [CODE_W-1:0] wiper_code,
    output logic              shutdown,
    output logic              code_load
);
    import wpot_pkg::*;

    localparam logic [IN_NUM-1:0] SYNC_RST = IN_NUM'((1 << IN_SEL) | (1 << IN_SHDN));

    logic [IN_NUM-1:0] raw_in, lvl;

    always_comb begin
        raw_in          = '0;
        raw_in[IN_SEL]  = sel_n;
        raw_in[IN_SCLK] = sclk;
        raw_in[IN_DATA] = sdata;
        raw_in[IN_SHDN] = shdn_n;
    end

    wpot_sync #(.N(IN_NUM), .RST_VAL(SYNC_RST)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (lvl)
    );

    wpot_core #(.W(CODE_W), .MID(CODE_MID)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_lvl  (lvl[IN_SEL]),
        .sclk_lvl (lvl[IN_SCLK]),
        .data_lvl (lvl[IN_DATA]),
        .code     (wiper_code),
        .load     (code_load)
    );

    assign shutdown = ~lvl[IN_SHDN];

    // R6: shutdown never disturbs the latch on its own
    p_shut_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_load && $changed(shutdown)) |-> $stable(wiper_code));
endmodule

// File: tb/wpot_ctrl_tb.sv
module wpot_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1, sclk = 1'b0, sdata = 1'b0, shdn_n = 1'b1;
    logic [7:0] code8;
    logic [5:0] code6;
    logic       shut8, shut6, load8, load6;

    always #2.5 clk = ~clk;

    wpot_ctrl #(.WIDE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdata(sdata),
        .shdn_n(shdn_n), .wiper_code(code8), .shutdown(shut8), .code_load(load8));

    wpot_ctrl #(.WIDE(1'b0)) u_dut_n (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdata(sdata),
        .shdn_n(shdn_n), .wiper_code(code6), .shutdown(shut6), .code_load(load6));

    int checks = 0, fails = 0;
    int edges = 0, pulses8 = 0, pulses6 = 0, wide_pulses = 0;
    bit done = 1'b0;
    logic       prev_load = 1'b0;
    logic [7:0] sr_m = 8'h00;   // model of the serial stream
    logic [7:0] exp8 = 8'h80;

    always @(negedge clk) begin
        if (rst_n) begin
            if (load8) pulses8++;
            if (load6) pulses6++;
            if (load8 && prev_load) wide_pulses++;
            prev_load = load8;
        end
    end

    function automatic logic [5:0] narrow_of(input logic [7:0] v);
        return v[5:0];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdata = b;
        wait_clk(4);
        sclk = 1'b1;
        wait_clk(4);
        sclk = 1'b0;
        sr_m = {sr_m[6:0], b};
    endtask

    // n bits, msb of the n-bit value first; checks R3 before releasing select
    task automatic frame(input int n, input logic [15:0] bits);
        @(negedge clk);
        sel_n = 1'b0;
        wait_clk(4);
        for (int i = n - 1; i >= 0; i--) send_bit(bits[i]);
        wait_clk(4);
        chk(code8 == exp8, "R3 code held during shifting", code8, exp8);
        sel_n = 1'b1;
        edges++;
        exp8 = sr_m;
        wait_clk(8);
        chk(code8 == exp8, "R2/R5 wide latch", code8, exp8);
        chk(code6 == narrow_of(exp8), "R9 narrow latch", code6, narrow_of(exp8));
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(6);

        // R1 reset state
        chk(code8 == 8'h80, "R1 wide midscale", code8, 8'h80);
        chk(code6 == 6'h10, "R1 R9 narrow midscale", code6, 6'h10);
        chk(!load8 && !load6, "R1 no pulse", load8, 0);
        chk(!shut8 && !shut6, "R1 shutdown low", shut8, 0);

        // R1: empty frame right after reset loads the cleared shift register
        frame(0, 16'h0);
        chk(code8 == 8'h00, "R1 shift register cleared", code8, 0);

        // R2 full word, msb first
        frame(8, 16'h00A5);
        chk(code8 == 8'hA5, "R2 word A5", code8, 8'hA5);
        frame(8, 16'h003C);
        chk(code6 == 6'h3C, "R9 low six bits", code6, 6'h3C);

        // R4 clocks with select high are ignored
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        sr_m = 8'h3C;  // undo model shifting: these edges must not count
        frame(3, 16'h0002);
        chk(code8 == 8'hE2, "R4 idle clocks ignored, R5 short frame", code8, 8'hE2);

        // R5 long frame keeps the last bits
        frame(12, 16'hF5A);
        chk(code8 == 8'h5A, "R5 long frame", code8, 8'h5A);

        // R6 shutdown keeps the latch
        shdn_n = 1'b0;
        wait_clk(4);
        chk(shut8 && shut6, "R6 shutdown flag", shut8, 1);
        chk(code8 == 8'h5A, "R6 latch kept on shutdown", code8, 8'h5A);
        // R7 load during shutdown
        frame(8, 16'h0017);
        chk(code8 == 8'h17 && shut8, "R7 load in shutdown", code8, 8'h17);
        shdn_n = 1'b1;
        wait_clk(4);
        chk(!shut8 && !shut6, "R6 shutdown released", shut8, 0);
        chk(code8 == 8'h17, "R6 R7 code after release", code8, 8'h17);

        // random frames with random shutdown toggles
        for (int k = 0; k < 40; k++) begin
            int n;
            logic [15:0] b;
            n = 1 + int'($urandom_range(11));
            b = 16'($urandom);
            if ($urandom_range(3) == 0) begin
                shdn_n = ~shdn_n;
                wait_clk(4);
                chk(shut8 == !shdn_n, "R6 random shutdown flag", shut8, !shdn_n);
                chk(code8 == exp8, "R6 random latch kept", code8, exp8);
            end
            frame(n, b);
        end
        shdn_n = 1'b1;
        wait_clk(4);

        // R8 pulse count and width
        chk(pulses8 == edges, "R8 wide pulse count", pulses8, edges);
        chk(pulses6 == edges, "R8 narrow pulse count", pulses6, edges);
        chk(wide_pulses == 0, "R8 pulse one cycle", wide_pulses, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule